// File: doc/BRIEF.md
# Periodic Clock Timer with Maskable Rate Interrupts

This block divides a 32.768 kHz oscillator tick, supplied as a one-cycle enable on the system clock, through a binary counter. Software reads four slow taps of that counter (16, 8, 4 and 2 Hz) as a nibble. It can also clear the counter. Three other rates (32, 16 and 2 Hz) each raise a pending flag on the falling edge of their tap. Each flag has its own enable bit. The interrupt request is the OR of every pending flag whose enable bit is set.

Software reaches the block over a small register bus: an 8-bit address, separate read and write strobes and 4-bit data. Read data is combinational from the address. A read strobe at the flag address empties all three pending flags at the next clock edge. A rate edge that lands in that same cycle wins, and its flag stays pending.

Top module: `clock_timer`

## Requirements
- R1: Each cycle with `osc_tick` high, and no counter clear, advances the 14-bit divider by one. Reading address 0xF2 returns divider bits 10, 11, 12 and 13 on data bits 0 to 3. These are the 16, 8, 4 and 2 Hz taps.
- R2: Address 0xF4 holds the enables in bits 0, 1 and 2, for the 32, 16 and 2 Hz sources. A write loads all three. Bit 3 always reads 0.
- R3: Writing 0xF4 with data bit 3 set clears the divider to zero at that edge, and no tick is counted. The pending flags are left as they were, and no flag is set by the clear.
- R4: Address 0xF6 returns the pending flags in bits 0, 1 and 2, for the 32, 16 and 2 Hz sources. Bit 3 reads 0.
- R5: A flag becomes pending at the edge where a counted tick takes its tap from 1 to 0. The taps are divider bit 9 (32 Hz), bit 10 (16 Hz) and bit 13 (2 Hz). The flag is set whether or not its enable bit is set, and only by such an edge.
- R6: A read strobe at 0xF6 returns the flags as they were before the edge, then clears all three at that edge.
- R7: When a tap edge and a read strobe at 0xF6 fall in the same cycle, that source's flag is pending after the edge.
- R8: `irq` is high exactly when some pending flag has its enable bit set.
- R9: While `rst_n` is low, the divider, the enables and the flags are zero and `irq` is low.
- R10: Writes to 0xF2 and 0xF6 change nothing. Any address other than 0xF2, 0xF4 and 0xF6 reads as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| osc_tick | input | 1 | One-cycle enable at the oscillator rate |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (side effect: clears flags at 0xF6) |
| bus_wdata | input | 4 | Write data |
| bus_rdata | output | 4 | Read data for the addressed register |
| irq | output | 1 | Interrupt request |

## Verification
The divider first runs with a tick on every cycle through complete 32 Hz, 16 Hz and 2 Hz periods. This shows that each flag follows its own tap and not a neighbouring one. Directed cases place a flag read on exactly the counting edge that ends a 32 Hz period, which separates set-wins behaviour from clear-wins behaviour. A counter clear with flags pending shows that the clear leaves the flags alone, and toggling the enables while flags are pending shows that the enables gate only `irq`. A long random phase then mixes sparse ticks, reads, writes and rare clears across all addresses. In that phase the bench's reference model catches taps that are off by one bit and flags that clear when they should not.

// File: rtl/ctmr_pkg.sv
package ctmr_pkg;

    localparam int unsigned NUM_SRC   = 3;
    localparam int unsigned NIB_W     = 4;
    localparam int unsigned NUM_TAPS  = 4;

    // source index: 0 = 32 Hz, 1 = 16 Hz, 2 = 2 Hz
    function automatic int unsigned src_tap_bit(input int unsigned div_w,
                                                input int unsigned idx);
        case (idx)
            0:       return div_w - 5;
            1:       return div_w - 4;
            default: return div_w - 1;
        endcase
    endfunction

    typedef struct packed {
        logic [NUM_SRC-1:0] pend;
        logic [NUM_SRC-1:0] ena;
    } flag_state_t;

    typedef struct packed {
        logic sel_taps;
        logic sel_ctl;
        logic sel_pend;
    } decode_t;

endpackage

// File: rtl/ctmr_divider.sv
module ctmr_divider
    import ctmr_pkg::*;
#(
    parameter int unsigned DIV_W = 14
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic               clear,
    output logic [DIV_W-1:0]   count,
    output logic [NUM_SRC-1:0] fall
);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } div_state_t;

    div_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clear) begin
            st_d.cnt = '0;
        end else if (tick) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count = st_q.cnt;

    // a tap bit drops exactly when every bit up to and including it is one
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_fall
        localparam int unsigned TAP = src_tap_bit(DIV_W, g);
        assign fall[g] = tick && !clear && (&st_q.cnt[TAP:0]);
    end

endmodule

// File: rtl/ctmr_flags.sv
module ctmr_flags
    import ctmr_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] fall,
    input  logic               pend_rd,
    input  logic               ctl_wr,
    input  logic [NUM_SRC-1:0] ena_wdata,
    output logic [NUM_SRC-1:0] pend,
    output logic [NUM_SRC-1:0] ena,
    output logic               irq
);

    flag_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ctl_wr) begin
            st_d.ena = ena_wdata;
        end
        for (int i = 0; i < NUM_SRC; i++) begin
            // an edge in the read cycle keeps its flag pending
            st_d.pend[i] = (st_q.pend[i] && !pend_rd) || fall[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend = st_q.pend;
    assign ena  = st_q.ena;
    assign irq  = |(st_q.pend & st_q.ena);

endmodule

// File: rtl/ctmr_regbus.sv
module ctmr_regbus
    import ctmr_pkg::*;
#(
    parameter int unsigned ADDR_W    = 8,
    parameter int unsigned DIV_W     = 14,
    parameter logic [ADDR_W-1:0] TAPS_ADDR = 8'hF2,
    parameter logic [ADDR_W-1:0] CTL_ADDR  = 8'hF4,
    parameter logic [ADDR_W-1:0] PEND_ADDR = 8'hF6
) (
    input  logic [ADDR_W-1:0]  addr,
    input  logic               wr,
    input  logic               rd,
    input  logic [NIB_W-1:0]   wdata,
    input  logic [DIV_W-1:0]   count,
    input  logic [NUM_SRC-1:0] pend,
    input  logic [NUM_SRC-1:0] ena,
    output logic               div_clear,
    output logic               ctl_wr,
    output logic               pend_rd,
    output logic [NIB_W-1:0]   rdata
);

    localparam int unsigned TAP_LO = DIV_W - NUM_TAPS;

    decode_t dec;

    always_comb begin
        dec.sel_taps = (addr == TAPS_ADDR);
        dec.sel_ctl  = (addr == CTL_ADDR);
        dec.sel_pend = (addr == PEND_ADDR);
    end

    assign ctl_wr    = wr && dec.sel_ctl;
    assign div_clear = ctl_wr && wdata[NIB_W-1];
    assign pend_rd   = rd && dec.sel_pend;

    always_comb begin
        rdata = '0;
        unique case (1'b1)
            dec.sel_taps: rdata = count[DIV_W-1:TAP_LO];
            dec.sel_ctl:  rdata = {1'b0, ena};
            dec.sel_pend: rdata = {1'b0, pend};
            default:      rdata = '0;
        endcase
    end

endmodule

// File: rtl/clock_timer.sv
module clock_timer
    import ctmr_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DIV_W  = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              osc_tick,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [NIB_W-1:0]  bus_wdata,
    output logic [NIB_W-1:0]  bus_rdata,
    output logic              irq
);

    logic [DIV_W-1:0]   div_count;
    logic [NUM_SRC-1:0] div_fall;
    logic [NUM_SRC-1:0] pend;
    logic [NUM_SRC-1:0] ena;
    logic               div_clear;
    logic               ctl_wr;
    logic               pend_rd;

    ctmr_divider #(.DIV_W(DIV_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (osc_tick),
        .clear (div_clear),
        .count (div_count),
        .fall  (div_fall)
    );

    ctmr_flags u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .fall      (div_fall),
        .pend_rd   (pend_rd),
        .ctl_wr    (ctl_wr),
        .ena_wdata (bus_wdata[NUM_SRC-1:0]),
        .pend      (pend),
        .ena       (ena),
        .irq       (irq)
    );

    ctmr_regbus #(.ADDR_W(ADDR_W), .DIV_W(DIV_W)) u_bus (
        .addr      (bus_addr),
        .wr        (bus_wr),
        .rd        (bus_rd),
        .wdata     (bus_wdata),
        .count     (div_count),
        .pend      (pend),
        .ena       (ena),
        .div_clear (div_clear),
        .ctl_wr    (ctl_wr),
        .pend_rd   (pend_rd),
        .rdata     (bus_rdata)
    );

endmodule

// File: rtl/clock_timer_chk.sv
module clock_timer_chk
    import ctmr_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DIV_W  = 14
) (
    input logic               clk,
    input logic               rst_n,
    input logic               osc_tick,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic               bus_wr,
    input logic               bus_rd,
    input logic [NIB_W-1:0]   bus_wdata,
    input logic [DIV_W-1:0]   count,
    input logic [NUM_SRC-1:0] fall,
    input logic [NUM_SRC-1:0] pend,
    input logic [NUM_SRC-1:0] ena
);

    logic clr_req, ctl_req, rd_req;
    assign ctl_req = bus_wr && (bus_addr == 8'hF4);
    assign clr_req = ctl_req && bus_wdata[3];
    assign rd_req  = bus_rd && (bus_addr == 8'hF6);

    a_r3_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
        clr_req |=> (count == '0));

    a_r1_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (osc_tick && !clr_req) |=> (count == DIV_W'($past(count) + 1'b1)));

    a_r7_edge_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (fall != '0) |=> ((pend & $past(fall)) == $past(fall)));

    a_r5_no_spurious_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (fall == '0) |=> ((pend & ~$past(pend)) == '0));

    a_r6_read_empties: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && fall == '0) |=> (pend == '0));

    a_r2_enables_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_req |=> $stable(ena));

endmodule

bind clock_timer clock_timer_chk #(.ADDR_W(ADDR_W), .DIV_W(DIV_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .osc_tick  (osc_tick),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .count     (div_count),
    .fall      (div_fall),
    .pend      (pend),
    .ena       (ena)
);

// File: tb/clock_timer_test.sv
module clock_timer_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       osc_tick = 1'b0;
    logic [7:0] bus_addr = 8'h00;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [3:0] bus_wdata = 4'h0;
    logic [3:0] bus_rdata;
    logic       irq;

    int unsigned n_checks = 0;
    int unsigned n_errors = 0;
    bit          finished = 1'b0;

    // reference model state
    logic [13:0] m_cnt  = '0;
    logic [2:0]  m_ena  = '0;
    logic [2:0]  m_pend = '0;

    always #10 clk = ~clk;

    clock_timer uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .osc_tick  (osc_tick),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [3:0] exp_rdata(input logic [7:0] a);
        case (a)
            8'hF2:   return m_cnt[13:10];
            8'hF4:   return {1'b0, m_ena};
            8'hF6:   return {1'b0, m_pend};
            default: return 4'h0;
        endcase
    endfunction

    function automatic string addr_tag(input logic [7:0] a);
        case (a)
            8'hF2:   return "R1";
            8'hF4:   return "R2";
            8'hF6:   return "R4";
            default: return "R10";
        endcase
    endfunction

    function automatic logic tap_falls(input logic [13:0] c, input int unsigned b);
        logic [13:0] n = c + 1'b1;
        return c[b] && !n[b];
    endfunction

    // one bus cycle: drive, check combinational outputs, clock, update model
    task automatic cyc(input logic osc, input logic wr, input logic rd,
                       input logic [7:0] a, input logic [3:0] wd);
        logic [2:0] fl;
        logic       clr;
        osc_tick = osc; bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = wd;
        #4;
        check(addr_tag(a), bus_rdata, exp_rdata(a));
        check("R8", {3'b0, irq}, {3'b0, |(m_pend & m_ena)});
        clr = wr && (a == 8'hF4) && wd[3];
        fl[0] = osc && !clr && tap_falls(m_cnt, 9);
        fl[1] = osc && !clr && tap_falls(m_cnt, 10);
        fl[2] = osc && !clr && tap_falls(m_cnt, 13);
        @(posedge clk);
        m_pend = ((rd && a == 8'hF6) ? 3'b000 : m_pend) | fl;
        if (wr && a == 8'hF4) m_ena = wd[2:0];
        if (clr) m_cnt = '0;
        else if (osc) m_cnt = m_cnt + 1'b1;
        #1;
    endtask

    task automatic peek(input string tag, input logic [7:0] a, input logic [3:0] exp);
        osc_tick = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = a;
        #2;
        check(tag, bus_rdata, exp);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        @(posedge clk); #1;
        // R9: reset state visible at the ports
        peek("R9", 8'hF2, 4'h0);
        peek("R9", 8'hF4, 4'h0);
        peek("R9", 8'hF6, 4'h0);
        check("R9", {3'b0, irq}, 4'h0);
        cyc(1, 1, 0, 8'hF4, 4'h7);              // ignored while in reset
        m_ena = '0; m_cnt = '0;
        peek("R9", 8'hF4, 4'h0);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;

        // R2: enables load
        cyc(0, 1, 0, 8'hF4, 4'h7);
        peek("R2", 8'hF4, 4'h7);
        // R10: writes to read-only addresses have no effect
        cyc(0, 1, 0, 8'hF6, 4'h7);
        cyc(0, 1, 0, 8'hF2, 4'hF);
        peek("R10", 8'hF6, 4'h0);
        peek("R10", 8'hF2, 4'h0);

        // R1/R5: run to count 1023, no flag yet
        for (int i = 0; i < 1023; i++) cyc(1, 0, 0, 8'hF2, 4'h0);
        peek("R5", 8'hF6, 4'h0);
        // R7: read of flags on the 32 Hz edge
        cyc(1, 0, 1, 8'hF6, 4'h0);
        peek("R7", 8'hF6, 4'h1);
        check("R8", {3'b0, irq}, 4'h1);
        // R6: plain read returns then clears
        cyc(0, 0, 1, 8'hF6, 4'h0);
        peek("R6", 8'hF6, 4'h0);

        // run to 2048: 32 and 16 Hz both pending
        for (int i = 0; i < 1024; i++) cyc(1, 0, 0, 8'hF2, 4'h0);
        peek("R5", 8'hF6, 4'h3);
        peek("R1", 8'hF2, 4'h2);
        // R3: clear divider and disable enables; flags untouched
        cyc(1, 1, 0, 8'hF4, 4'h8);
        peek("R3", 8'hF2, 4'h0);
        peek("R3", 8'hF6, 4'h3);
        check("R8", {3'b0, irq}, 4'h0);

        // slow source alone: enable 2 Hz, clear flags, run a full period
        cyc(0, 1, 1, 8'hF6, 4'h0);
        cyc(0, 1, 0, 8'hF4, 4'hC);              // clear + enable 2 Hz
        for (int i = 0; i < 16384; i++) cyc(1, 0, 0, 8'hF2, 4'h0);
        peek("R5", 8'hF6, 4'h7);
        check("R8", {3'b0, irq}, 4'h1);
        peek("R1", 8'hF2, 4'h0);

        // random mix
        for (int i = 0; i < 8000; i++) begin
            logic [7:0] a;
            logic [3:0] wd;
            case ($urandom % 5)
                0: a = 8'hF2;
                1: a = 8'hF4;
                2: a = 8'hF6;
                3: a = 8'hF0;
                default: a = 8'($urandom);
            endcase
            wd = 4'($urandom);
            wd[3] = (($urandom % 32) == 0);
            cyc(($urandom % 8) != 0, ($urandom % 4) == 0, ($urandom % 3) == 0, a, wd);
        end

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule